// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This peripheral guards a system against a stalled processor. A 10-bit counter is loaded from a programmable start value and steps down once per slow tick. The tick comes from a parameterised prescaler that divides the system clock to a 0.6 s period. If software does not reload the counter in time, the counter runs past zero and the first timeout occurs. The first timeout sets a sticky flag, can raise an interrupt, reloads the counter and starts a second countdown. If the second countdown also runs out, a second-timeout flag is set and a one-cycle system reset request is issued. A lock bit can mask that reset request.

Software uses a small register bus with 16-bit data and per-byte write enables. A write of any value to the reload register restarts the countdown. A read of the same register returns the live count. Clearing the first-timeout flag before the second expiry sends the block back to first-stage behaviour.

The sequencing is a three-state machine:
- `WD_HALTED`: the counter is frozen. Leaving this state happens when the halt bit is cleared. The machine goes to `WD_STAGE2` if the first-timeout flag is still set, otherwise to `WD_STAGE1`.
- `WD_STAGE1`: the block counts toward a first timeout. On a first expiry it moves to `WD_STAGE2`. Setting the halt bit returns it to `WD_HALTED`.
- `WD_STAGE2`: the block counts toward a second timeout. A second expiry keeps it in `WD_STAGE2`. Clearing the first-timeout flag sends it back to `WD_STAGE1`, unless an expiry lands in the same cycle. Setting the halt bit returns it to `WD_HALTED`.

Top module: `dual_stage_wdt`

## Requirements
- R1: After a synchronous reset, the block comes up in this state:
  - halted, with CTRL (0x08) reading 0x0800;
  - start value and live count both 4;
  - both status registers 0;
  - LOCK (0x0A) reading 0x0001;
  - IRQEN (0x0C) reading 0;
  - `irq_o` and `rst_req_o` low.
- R2: While running, the count drops by one every DIV = CLK_KHZ*TICK_MS clock cycles. The first step lands DIV cycles after the halt bit is cleared. A read of RELOAD (0x00) returns the live count in bits [9:0], with the other bits zero.
- R3: A write of any data, with any byte enable set, to RELOAD (0x00) loads the count with the start value on the next clock edge. It also restarts the prescaler phase.
- R4: START (0x12) holds the start value in bits [9:0]. Bits [15:10] read as zero. Writes merge by byte enable. A merged value below 4 is ignored and the previous value is kept.
- R5: Bit 11 of CTRL (0x08) is the halt bit. While it is 1 the count does not change, except through a reload.
- R6: When a tick arrives with the count at zero, the block expires:
  - the count reloads to the start value;
  - on a first expiry, bit 3 of STS_A (0x04) is set.
  
  The first expiry after start takes (start+1)*DIV cycles from the halt release.
- R7: An expiry that arrives while STS_A bit 3 is still set is a second expiry. It sets bit 1 of STS_B (0x06) and reloads the count.
- R8: A second expiry raises `rst_req_o` for exactly one cycle on the same edge that sets STS_B bit 1, and also sets the sticky boot flag, STS_B bit 2. Both are suppressed while LOCK (0x0A) bit 0 is 1. That bit reads back what was written.
- R9: `irq_o` is high exactly while STS_A bit 3 is 1 and IRQEN (0x0C) bit 13 is 1.
- R10: The status bits are cleared by writing 1 to them. A set and a clear of the same bit in the same cycle leave it set. If STS_A bit 3 is cleared before the second expiry, the next expiry counts as a first expiry again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_be | input | 2 | Byte enables for the write |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | First-timeout interrupt, level |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
Some properties are checked on every cycle by the assertions:
- the count freezes while halted;
- a reload takes the start value;
- the count steps by one per tick;
- first and second expiry never coincide;
- the start value never falls below 4;
- the reset request lasts one cycle and only appears with the lock clear.

Other behaviour shows only in the bench's scenarios. These cover the exact expiry cycles, the stage reversal after the first-timeout flag is cleared, the byte-lane merge and the ignored small start values. They also cover the masking of the reset request and the boot flag by the lock.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 5;

    typedef enum logic [1:0] {
        WD_HALTED = 2'd0,
        WD_STAGE1 = 2'd1,
        WD_STAGE2 = 2'd2
    } wd_state_t;

    localparam logic [ADDR_W-1:0] OFS_RELOAD = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_STS_A  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_STS_B  = 5'h06;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_LOCK   = 5'h0A;
    localparam logic [ADDR_W-1:0] OFS_IRQEN  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_START  = 5'h12;

    localparam int BIT_HALT   = 11;
    localparam int BIT_FIRST  = 3;
    localparam int BIT_SECOND = 1;
    localparam int BIT_BOOT   = 2;
    localparam int BIT_LOCK   = 0;
    localparam int BIT_IRQEN  = 13;
endpackage

// File: rtl/wdt2_prescaler.sv
module wdt2_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick = (phase_q == LAST);
endmodule

// File: rtl/wdt2_countdown.sv
module wdt2_countdown
    import wdt2_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int INIT_RST = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             halt,
    input  logic             reload,
    input  logic [CNT_W-1:0] start_val,
    input  logic             first_flag,
    output logic [CNT_W-1:0] count,
    output logic             exp_first,
    output logic             exp_second
);
    wd_state_t     state_q, state_nxt;
    logic [CNT_W-1:0] count_q;
    logic          running;
    logic          expire;

    assign running = (state_q != WD_HALTED) && !halt;
    assign expire  = running && tick && !reload && (count_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WD_HALTED;
        end else begin
            state_q <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            WD_HALTED: begin
                if (!halt) state_nxt = first_flag ? WD_STAGE2 : WD_STAGE1;
            end
            WD_STAGE1: begin
                if (halt)        state_nxt = WD_HALTED;
                else if (expire) state_nxt = WD_STAGE2;
            end
            WD_STAGE2: begin
                if (halt)                         state_nxt = WD_HALTED;
                else if (!first_flag && !expire)  state_nxt = WD_STAGE1;
            end
            default: state_nxt = WD_HALTED;
        endcase
    end

    always_comb begin
        exp_first  = 1'b0;
        exp_second = 1'b0;
        unique case (state_q)
            WD_HALTED: ;
            WD_STAGE1: exp_first = expire;
            WD_STAGE2: begin
                exp_second = expire && first_flag;
                exp_first  = expire && !first_flag;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= CNT_W'(INIT_RST);
        end else if (reload) begin
            count_q <= start_val;
        end else if (running && tick) begin
            count_q <= (count_q == '0) ? start_val : count_q - 1'b1;
        end
    end

    assign count = count_q;

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (halt && !reload) |=> (count_q == $past(count_q))); // R5
    AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (rst)
        reload |=> (count_q == $past(start_val))); // R3
    AST_TICK_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && !halt && !reload && state_q != WD_HALTED && count_q != '0)
        |=> (count_q == $past(count_q) - 1'b1)); // R2
    AST_EXP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({exp_first, exp_second})); // R6
endmodule

// File: rtl/wdt2_regs.sv
module wdt2_regs
    import wdt2_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int INIT_MIN = 4,
    parameter int INIT_RST = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [1:0]        bus_be,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              exp_first,
    input  logic              exp_second,
    output logic              halt,
    output logic              reload,
    output logic [CNT_W-1:0]  start_val,
    output logic              first_flag,
    output logic              irq,
    output logic              rst_req
);
    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(INIT_MIN);

    logic             halt_q, lock_q, irqen_q;
    logic             first_q, second_q, boot_q, rst_req_q;
    logic [CNT_W-1:0] start_q;
    logic [DATA_W-1:0] start_ext, start_merged;
    logic [CNT_W-1:0] start_cand;
    logic             any_be;

    function automatic logic [DATA_W-1:0] merge_lanes(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [1:0]        be);
        return {be[1] ? new_v[15:8] : old_v[15:8],
                be[0] ? new_v[7:0]  : old_v[7:0]};
    endfunction

    function automatic logic hit(
        input logic              wr,
        input logic [ADDR_W-1:0] a,
        input logic [ADDR_W-1:0] ofs);
        return wr && (a == ofs);
    endfunction

    assign any_be = |bus_be;

    always_comb begin
        start_ext = '0;
        start_ext[CNT_W-1:0] = start_q;
        start_merged = merge_lanes(start_ext, bus_wdata, bus_be);
        start_cand   = start_merged[CNT_W-1:0];
    end

    assign reload = hit(bus_wr, bus_addr, OFS_RELOAD) && any_be;

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_q    <= 1'b1;
            lock_q    <= 1'b1;
            irqen_q   <= 1'b0;
            start_q   <= CNT_W'(INIT_RST);
            first_q   <= 1'b0;
            second_q  <= 1'b0;
            boot_q    <= 1'b0;
            rst_req_q <= 1'b0;
        end else begin
            if (hit(bus_wr, bus_addr, OFS_CTRL) && bus_be[1])
                halt_q <= bus_wdata[BIT_HALT];
            if (hit(bus_wr, bus_addr, OFS_LOCK) && bus_be[0])
                lock_q <= bus_wdata[BIT_LOCK];
            if (hit(bus_wr, bus_addr, OFS_IRQEN) && bus_be[1])
                irqen_q <= bus_wdata[BIT_IRQEN];
            if (hit(bus_wr, bus_addr, OFS_START) && any_be && (start_cand >= MIN_V))
                start_q <= start_cand;

            if (exp_first)
                first_q <= 1'b1;
            else if (hit(bus_wr, bus_addr, OFS_STS_A) && bus_be[0] && bus_wdata[BIT_FIRST])
                first_q <= 1'b0;

            if (exp_second)
                second_q <= 1'b1;
            else if (hit(bus_wr, bus_addr, OFS_STS_B) && bus_be[0] && bus_wdata[BIT_SECOND])
                second_q <= 1'b0;

            if (exp_second && !lock_q)
                boot_q <= 1'b1;
            else if (hit(bus_wr, bus_addr, OFS_STS_B) && bus_be[0] && bus_wdata[BIT_BOOT])
                boot_q <= 1'b0;

            rst_req_q <= exp_second && !lock_q;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_RELOAD: bus_rdata[CNT_W-1:0] = count;
            OFS_STS_A:  bus_rdata[BIT_FIRST] = first_q;
            OFS_STS_B: begin
                bus_rdata[BIT_SECOND] = second_q;
                bus_rdata[BIT_BOOT]   = boot_q;
            end
            OFS_CTRL:   bus_rdata[BIT_HALT]  = halt_q;
            OFS_LOCK:   bus_rdata[BIT_LOCK]  = lock_q;
            OFS_IRQEN:  bus_rdata[BIT_IRQEN] = irqen_q;
            OFS_START:  bus_rdata[CNT_W-1:0] = start_q;
            default:    bus_rdata = '0;
        endcase
    end

    assign halt       = halt_q;
    assign start_val  = start_q;
    assign first_flag = first_q;
    assign irq        = first_q && irqen_q;
    assign rst_req    = rst_req_q;

    AST_START_FLOOR: assert property (@(posedge clk) disable iff (rst)
        start_q >= MIN_V); // R4
    AST_RSTREQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        rst_req_q |=> !rst_req_q); // R8
    AST_LOCK_MASK: assert property (@(posedge clk) disable iff (rst)
        rst_req_q |-> ($past(!lock_q) && boot_q && second_q)); // R8
endmodule

// File: rtl/dual_stage_wdt.sv
module dual_stage_wdt
    import wdt2_pkg::*;
#(
    parameter int CLK_KHZ  = 100000,
    parameter int TICK_MS  = 600,
    parameter int CNT_W    = 10,
    parameter int INIT_MIN = 4,
    parameter int INIT_RST = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    input  logic [1:0]  bus_be,
    output logic [15:0] bus_rdata,
    output logic        irq_o,
    output logic        rst_req_o
);
    localparam int DIV = CLK_KHZ * TICK_MS;

    logic             tick, halt, reload, first_flag;
    logic             exp_first, exp_second;
    logic [CNT_W-1:0] count, start_val;

    wdt2_prescaler #(.DIV(DIV)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .clr  (halt | reload),
        .tick (tick)
    );

    wdt2_countdown #(.CNT_W(CNT_W), .INIT_RST(INIT_RST)) u_count (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .halt       (halt),
        .reload     (reload),
        .start_val  (start_val),
        .first_flag (first_flag),
        .count      (count),
        .exp_first  (exp_first),
        .exp_second (exp_second)
    );

    wdt2_regs #(.CNT_W(CNT_W), .INIT_MIN(INIT_MIN), .INIT_RST(INIT_RST)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_be     (bus_be),
        .bus_rdata  (bus_rdata),
        .count      (count),
        .exp_first  (exp_first),
        .exp_second (exp_second),
        .halt       (halt),
        .reload     (reload),
        .start_val  (start_val),
        .first_flag (first_flag),
        .irq        (irq_o),
        .rst_req    (rst_req_o)
    );
endmodule

// File: tb/test_dual_stage_wdt.sv
`timescale 1ns/1ps
module test_dual_stage_wdt;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_rdata;
    logic        irq_o, rst_req_o;

    int tests = 0;
    int fails = 0;
    int rst_seen = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dual_stage_wdt #(.CLK_KHZ(1), .TICK_MS(4)) i_dual_stage_wdt (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    always @(negedge clk) if (!rst && rst_req_o) rst_seen++;

    // {write data, expected start value after the write}
    localparam logic [31:0] VEC [0:5] = '{
        {16'h0005, 16'h0005},
        {16'h0003, 16'h0005},
        {16'h0000, 16'h0005},
        {16'h03FF, 16'h03FF},
        {16'hFC07, 16'h0007},
        {16'h0004, 16'h0004}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d, input logic [1:0] be);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    logic [15:0] v, v2;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(5'h08, v); chk("R1 ctrl", v, 16'h0800);
        rd(5'h12, v); chk("R1 start", v, 16'h0004);
        rd(5'h00, v); chk("R1 count", v, 16'h0004);
        rd(5'h04, v); chk("R1 sts_a", v, 16'h0000);
        rd(5'h06, v); chk("R1 sts_b", v, 16'h0000);
        rd(5'h0A, v); chk("R1 lock", v, 16'h0001);
        rd(5'h0C, v); chk("R1 irqen", v, 16'h0000);
        chk("R1 irq", {15'd0, irq_o}, 16'h0000);
        chk("R1 rst_req", {15'd0, rst_req_o}, 16'h0000);

        // Table: R4 start-value writes, R3 reload loads it
        for (int i = 0; i < 6; i++) begin
            wr(5'h12, VEC[i][31:16], 2'b11);
            rd(5'h12, v); chk("R4 start write", v, VEC[i][15:0]);
            wr(5'h00, 16'h0001, 2'b01);
            rd(5'h00, v); chk("R3 reload count", v, VEC[i][15:0]);
        end
        // R4 byte-lane merge: upper lane only on start value 4 -> 0x0104
        wr(5'h12, 16'h0100, 2'b10);
        rd(5'h12, v); chk("R4 lane merge", v, 16'h0104);
        wr(5'h12, 16'h0005, 2'b11);
        wr(5'h00, 16'h0000, 2'b11);

        // Scenario A: two-stage expiry with lock clear, start 5, DIV 4
        wr(5'h0A, 16'h0000, 2'b11);
        rd(5'h0A, v); chk("R8 lock readback", v, 16'h0000);
        wr(5'h0C, 16'h2000, 2'b11);
        wr(5'h08, 16'h0000, 2'b11);       // halt release edge = E0
        waitn(3);  rd(5'h00, v); chk("R2 before first tick", v, 16'h0005);
        waitn(1);  rd(5'h00, v); chk("R2 first tick", v, 16'h0004);
        waitn(19); rd(5'h04, v); chk("R6 not yet expired", v, 16'h0000);
        waitn(1);  rd(5'h04, v); chk("R6 first expiry", v, 16'h0008);
        rd(5'h00, v); chk("R6 reload on expiry", v, 16'h0005);
        chk("R9 irq on", {15'd0, irq_o}, 16'h0001);
        waitn(23); rd(5'h06, v); chk("R7 before second", v, 16'h0000);
        chk("R8 no early req", {15'd0, rst_req_o}, 16'h0000);
        waitn(1);  rd(5'h06, v); chk("R7 R8 second expiry", v, 16'h0006);
        chk("R8 rst_req high", {15'd0, rst_req_o}, 16'h0001);
        waitn(1);  chk("R8 rst_req one cycle", {15'd0, rst_req_o}, 16'h0000);
        chk("R8 single pulse", 16'(rst_seen), 16'h0001);

        // Scenario B: clearing the first flag reverts to first stage (R10)
        wr(5'h08, 16'h0800, 2'b11);
        wr(5'h06, 16'h0006, 2'b01);
        rd(5'h06, v); chk("R10 sts_b w1c", v, 16'h0000);
        wr(5'h04, 16'h0008, 2'b01);
        rd(5'h04, v); chk("R10 sts_a w1c", v, 16'h0000);
        chk("R9 irq off", {15'd0, irq_o}, 16'h0000);
        wr(5'h00, 16'h0001, 2'b11);
        wr(5'h08, 16'h0000, 2'b11);       // E0
        waitn(24); rd(5'h04, v); chk("R6 again first", v, 16'h0008);
        waitn(1);
        wr(5'h04, 16'h0008, 2'b01);       // clear at E26
        waitn(22);
        rd(5'h04, v); chk("R10 re-first expiry", v, 16'h0008);
        rd(5'h06, v); chk("R10 no second", v, 16'h0000);

        // Scenario C: lock set masks reset request and boot flag (R8)
        wr(5'h08, 16'h0800, 2'b11);
        wr(5'h0A, 16'h0001, 2'b01);
        wr(5'h04, 16'h0008, 2'b01);
        wr(5'h12, 16'h0004, 2'b11);
        wr(5'h00, 16'h0001, 2'b11);
        wr(5'h08, 16'h0000, 2'b11);       // E0
        waitn(20); rd(5'h04, v); chk("R6 start4 first", v, 16'h0008);
        waitn(20); rd(5'h06, v); chk("R8 lock no boot", v, 16'h0002);
        chk("R8 lock no pulse", 16'(rst_seen), 16'h0001);

        // R5 halt freezes count; R9 enable gating
        wr(5'h08, 16'h0800, 2'b10);
        rd(5'h00, v); waitn(12); rd(5'h00, v2);
        chk("R5 halt freeze", v2, v);
        wr(5'h0C, 16'h0000, 2'b11);
        chk("R9 irq masked", {15'd0, irq_o}, 16'h0000);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog timeout");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule